// File: doc/BRIEF.md
# Layered Maze Routing Cell

This block is one processing element of a two-dimensional maze routing array. It sits at a single (x,y) grid position and keeps the routing state of every layer of the routing stack at that position. It does not hold all layers side by side. It holds the layer in work in one entry register and the rest in a ring of entries. Each command steps through the layers one at a time, bottom to top, and wraps from the top layer back to the bottom. Every cell in the array steps in lockstep, so the planar neighbour inputs always refer to the same layer as the cell's own current layer.

A controller broadcasts one command per cycle to the whole array. A cell changes state only when both its row-select and its column-select are high. The commands are:

- read the current layer's state;
- write a state into it;
- expand the wavefront into it from an already expanded neighbour, optionally etching through an occupied cell;
- clear the expansion marks.

Each layer entry is a small state machine over eight codes. EMPTY and BLOCKED are the resting states. The six expanded states name the neighbour that the shortest path back to the source passes through. An etched flag records that an expanded entry was BLOCKED before, so that a clear can restore the obstacle.

The transitions, on a selected cell, are:

- any state to any code on WRITE;
- EMPTY to an expanded state on EXPAND;
- BLOCKED to an etched expanded state on EXPAND with etch enabled;
- expanded to EMPTY on CLEARX if not etched;
- etched expanded to BLOCKED on CLEARX.

In all other cases an entry holds its state. Read data is zero from unselected cells, so the array can OR it together. The status bits of the cells can be ANDed into one array status.

The stack depth `NL` must be at least 2.

Top module: `maze_layer_cell`

## Requirements
- R1: After reset every layer holds EMPTY (code 0) with the etched flag clear, `layer_o` is 0, `rd_o` is 0, `xp_o` is 0 and `status_o` is 1.
- R2: Command codes are NOP=0, READ=1, WRITE=2, EXPAND=3 and CLEARX=4; codes 5 to 7 act as NOP. Every one of the four active commands is applied to the current layer and then advances `layer_o` by one, wrapping from NL-1 to 0, whether or not the cell is selected. A NOP leaves `layer_o` unchanged.
- R3: State codes are EMPTY=0, BLOCKED=1, XN=2, XS=3, XE=4, XW=5, XU=6 and XD=7. A WRITE to a selected cell stores `wr_code_i` in the current layer and clears its etched flag. If `row_sel_i` or `col_sel_i` is low, the entry is unchanged.
- R4: The cycle after a READ to a selected cell, `rd_o` carries the code of the layer that was read. After any other cycle, `rd_o` is 0.
- R5: On EXPAND, a selected EMPTY entry with at least one expanded neighbour enters the expanded state toward one of them. The priority, highest first, is north (XN), south (XS), east (XE), west (XW), the layer above (XU) and the layer below (XD).
- R6: On EXPAND with an expanded neighbour, a selected BLOCKED entry enters the direction state of R5 with its etched flag set when `etch_i` is 1. It stays BLOCKED when `etch_i` is 0.
- R7: On EXPAND, an entry with no expanded neighbour keeps its state, and an entry that is already expanded keeps its direction.
- R8: Vertical neighbours are the layers directly above and below the current layer, the lower one already updated in the current pass. The bottom layer has no lower neighbour and the top layer has no upper neighbour, even though the ring holds the opposite end of the stack there.
- R9: On CLEARX, a selected expanded entry becomes EMPTY if its etched flag is clear, or BLOCKED if the flag is set, and the flag is cleared. EMPTY and BLOCKED entries are unchanged.
- R10: `xp_o` is 1 exactly when the current layer's code is one of the six expanded codes (2 to 7).
- R11: `status_o` is 0 exactly when both selects are high and the current layer is expanded; otherwise it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_i | input | 3 | Broadcast command code |
| row_sel_i | input | 1 | Row decoder select |
| col_sel_i | input | 1 | Column decoder select |
| etch_i | input | 1 | Allow expansion through BLOCKED entries |
| wr_code_i | input | 3 | State code stored by WRITE |
| nb_xp_n_i | input | 1 | North neighbour's current layer is expanded |
| nb_xp_s_i | input | 1 | South neighbour's current layer is expanded |
| nb_xp_e_i | input | 1 | East neighbour's current layer is expanded |
| nb_xp_w_i | input | 1 | West neighbour's current layer is expanded |
| xp_o | output | 1 | Current layer is expanded (to the neighbours) |
| status_o | output | 1 | Per-cell status, low when selected and expanded |
| rd_o | output | 3 | Read data, zero unless a selected READ was done |
| layer_o | output | $clog2(NL) | Index of the current layer |

## Verification
Within one EXPAND step the cell can see an expanded planar neighbour and an expanded vertical neighbour at the same time. It can also see both the layer above and the layer below expanded at once. The bench sets up stacks in which both conditions hold: it drives several neighbour inputs together and writes expanded codes into the layers on either side of an EMPTY one. The recorded direction is judged against the fixed priority order. The bench also places an expanded entry at the far end of the stack, so that it sits in the ring slot next to the bottom or top layer, and expects it to be ignored.

// File: rtl/maze_cell_pkg.sv
package maze_cell_pkg;

    typedef enum logic [2:0] {
        C_EMPTY   = 3'd0,
        C_BLOCKED = 3'd1,
        C_XN      = 3'd2,
        C_XS      = 3'd3,
        C_XE      = 3'd4,
        C_XW      = 3'd5,
        C_XU      = 3'd6,
        C_XD      = 3'd7
    } cell_code_e;

    typedef enum logic [2:0] {
        OP_NOP    = 3'd0,
        OP_READ   = 3'd1,
        OP_WRITE  = 3'd2,
        OP_EXPAND = 3'd3,
        OP_CLEARX = 3'd4
    } op_e;

    typedef struct packed {
        logic       etched;
        cell_code_e code;
    } layer_entry_t;

    function automatic logic is_expanded(cell_code_e c);
        return (c != C_EMPTY) && (c != C_BLOCKED);
    endfunction

endpackage

// File: rtl/mc_layer_stack.sv
module mc_layer_stack
    import maze_cell_pkg::*;
#(
    parameter  int NL = 4,
    localparam int LW = (NL > 1) ? $clog2(NL) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_i,
    input  layer_entry_t upd_i,
    output layer_entry_t cur_o,
    output layer_entry_t above_o,
    output layer_entry_t below_o,
    output logic         at_top_o,
    output logic         at_bot_o,
    output logic [LW-1:0] layer_o
);

    layer_entry_t    cur_q;
    layer_entry_t    ring_q [NL-1];
    logic [LW-1:0]   lay_q;

    // Ring order: ring_q[0] is the next layer up, ring_q[NL-2] the one just left.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
            lay_q <= '0;
            for (int i = 0; i < NL - 1; i++) ring_q[i] <= '0;
        end else if (step_i) begin
            cur_q <= ring_q[0];
            for (int i = 0; i < NL - 2; i++) ring_q[i] <= ring_q[i+1];
            ring_q[NL-2] <= upd_i;
            lay_q <= (lay_q == LW'(NL - 1)) ? '0 : lay_q + LW'(1);
        end
    end

    assign cur_o    = cur_q;
    assign above_o  = ring_q[0];
    assign below_o  = ring_q[NL-2];
    assign at_top_o = (lay_q == LW'(NL - 1));
    assign at_bot_o = (lay_q == '0);
    assign layer_o  = lay_q;

endmodule

// File: rtl/mc_next_entry.sv
module mc_next_entry
    import maze_cell_pkg::*;
(
    input  op_e          op_i,
    input  logic         sel_i,
    input  logic         etch_i,
    input  cell_code_e   wr_code_i,
    input  layer_entry_t cur_i,
    input  logic         nb_n_i,
    input  logic         nb_s_i,
    input  logic         nb_e_i,
    input  logic         nb_w_i,
    input  logic         up_x_i,
    input  logic         dn_x_i,
    output layer_entry_t nxt_o
);

    cell_code_e dir;
    logic       found;

    always_comb begin
        found = 1'b1;
        dir   = C_EMPTY;
        if (nb_n_i)      dir = C_XN;
        else if (nb_s_i) dir = C_XS;
        else if (nb_e_i) dir = C_XE;
        else if (nb_w_i) dir = C_XW;
        else if (up_x_i) dir = C_XU;
        else if (dn_x_i) dir = C_XD;
        else             found = 1'b0;
    end

    always_comb begin
        nxt_o = cur_i;
        if (sel_i) begin
            unique case (op_i)
                OP_WRITE: begin
                    nxt_o.etched = 1'b0;
                    nxt_o.code   = wr_code_i;
                end
                OP_EXPAND: begin
                    if (found) begin
                        unique case (cur_i.code)
                            C_EMPTY: begin
                                nxt_o.code   = dir;
                                nxt_o.etched = 1'b0;
                            end
                            C_BLOCKED: begin
                                if (etch_i) begin
                                    nxt_o.code   = dir;
                                    nxt_o.etched = 1'b1;
                                end
                            end
                            default: ;
                        endcase
                    end
                end
                OP_CLEARX: begin
                    if (is_expanded(cur_i.code)) begin
                        nxt_o.code   = cur_i.etched ? C_BLOCKED : C_EMPTY;
                        nxt_o.etched = 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/maze_layer_cell.sv
module maze_layer_cell
    import maze_cell_pkg::*;
#(
    parameter  int NL = 4,
    localparam int LW = (NL > 1) ? $clog2(NL) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    cmd_i,
    input  logic          row_sel_i,
    input  logic          col_sel_i,
    input  logic          etch_i,
    input  logic [2:0]    wr_code_i,
    input  logic          nb_xp_n_i,
    input  logic          nb_xp_s_i,
    input  logic          nb_xp_e_i,
    input  logic          nb_xp_w_i,
    output logic          xp_o,
    output logic          status_o,
    output logic [2:0]    rd_o,
    output logic [LW-1:0] layer_o
);

    op_e          op;
    logic         sel, step;
    layer_entry_t cur_e, above_e, below_e, nxt_e;
    logic         at_top, at_bot, up_x, dn_x;
    logic [2:0]   rd_q;
    logic [2:0]   cur_code_w, nxt_code_w;
    logic         nxt_etch_w;

    assign op   = op_e'(cmd_i);
    assign sel  = row_sel_i && col_sel_i;
    assign step = (op == OP_READ) || (op == OP_WRITE) ||
                  (op == OP_EXPAND) || (op == OP_CLEARX);

    mc_layer_stack #(.NL(NL)) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_i   (step),
        .upd_i    (nxt_e),
        .cur_o    (cur_e),
        .above_o  (above_e),
        .below_o  (below_e),
        .at_top_o (at_top),
        .at_bot_o (at_bot),
        .layer_o  (layer_o)
    );

    assign up_x = !at_top && is_expanded(above_e.code);
    assign dn_x = !at_bot && is_expanded(below_e.code);

    mc_next_entry u_next (
        .op_i      (op),
        .sel_i     (sel),
        .etch_i    (etch_i),
        .wr_code_i (cell_code_e'(wr_code_i)),
        .cur_i     (cur_e),
        .nb_n_i    (nb_xp_n_i),
        .nb_s_i    (nb_xp_s_i),
        .nb_e_i    (nb_xp_e_i),
        .nb_w_i    (nb_xp_w_i),
        .up_x_i    (up_x),
        .dn_x_i    (dn_x),
        .nxt_o     (nxt_e)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= (sel && op == OP_READ) ? cur_e.code : 3'd0;
    end

    always_comb begin
        xp_o     = is_expanded(cur_e.code);
        status_o = !(sel && xp_o);
        rd_o     = rd_q;
    end

    assign cur_code_w = cur_e.code;
    assign nxt_code_w = nxt_e.code;
    assign nxt_etch_w = nxt_e.etched;

endmodule

// File: rtl/maze_layer_cell_chk.sv
module maze_layer_cell_chk #(
    parameter  int NL = 4,
    localparam int LW = (NL > 1) ? $clog2(NL) : 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic [2:0]    cmd_i,
    input logic          row_sel_i,
    input logic          col_sel_i,
    input logic          etch_i,
    input logic [2:0]    wr_code_i,
    input logic          xp_o,
    input logic          status_o,
    input logic [2:0]    rd_o,
    input logic [LW-1:0] layer_o,
    input logic [2:0]    cur_code,
    input logic [2:0]    nxt_code,
    input logic          nxt_etched
);

    logic active, sel;
    assign active = (cmd_i >= 3'd1) && (cmd_i <= 3'd4);
    assign sel    = row_sel_i && col_sel_i;

    // R2
    layer_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active |=> layer_o == (($past(layer_o) == LW'(NL - 1)) ? '0 : $past(layer_o) + LW'(1)));

    // R2
    layer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> $stable(layer_o));

    // R4
    rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_i == 3'd1 && sel) |=> rd_o == 3'd0);

    // R11
    status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_o == !(sel && xp_o));

    // R3
    write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == 3'd2 && sel) |-> (nxt_code == wr_code_i && !nxt_etched));

    // R6
    no_etch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == 3'd3 && !etch_i && cur_code == 3'd1) |-> nxt_code == 3'd1);

    // R9
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == 3'd4 && sel) |-> (nxt_code <= 3'd1 && !nxt_etched));

endmodule

bind maze_layer_cell maze_layer_cell_chk #(.NL(NL)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_i      (cmd_i),
    .row_sel_i  (row_sel_i),
    .col_sel_i  (col_sel_i),
    .etch_i     (etch_i),
    .wr_code_i  (wr_code_i),
    .xp_o       (xp_o),
    .status_o   (status_o),
    .rd_o       (rd_o),
    .layer_o    (layer_o),
    .cur_code   (cur_code_w),
    .nxt_code   (nxt_code_w),
    .nxt_etched (nxt_etch_w)
);

// File: tb/test_maze_layer_cell.sv
module test_maze_layer_cell;

    localparam int NL = 4;
    localparam int LW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    cmd = '0;
    logic          rs = 1'b0, cs = 1'b0, et = 1'b0;
    logic [2:0]    wr = '0;
    logic [3:0]    nb = '0;
    logic          xp_o, status_o;
    logic [2:0]    rd_o;
    logic [LW-1:0] layer_o;

    always #5 clk = ~clk;

    maze_layer_cell #(.NL(NL)) i_maze_layer_cell (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_i     (cmd),
        .row_sel_i (rs),
        .col_sel_i (cs),
        .etch_i    (et),
        .wr_code_i (wr),
        .nb_xp_n_i (nb[3]),
        .nb_xp_s_i (nb[2]),
        .nb_xp_e_i (nb[1]),
        .nb_xp_w_i (nb[0]),
        .xp_o      (xp_o),
        .status_o  (status_o),
        .rd_o      (rd_o),
        .layer_o   (layer_o)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit done = 1'b0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct { int due; int rd; int lay; string req; } exp_t;
    exp_t sb_q[$];

    int m_code [NL];
    bit m_etch [NL];
    int m_lay = 0;

    function automatic bit isx(int c);
        return c >= 2;
    endfunction

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Driver: apply one command for one cycle and push the expected result.
    task automatic issue(int op, bit r, bit c, bit e, int w, bit [3:0] n, string req);
        int  exp_rd, L, dir;
        bit  sel, a, b;
        @(posedge clk); #1;
        cmd = op[2:0]; rs = r; cs = c; et = e; wr = w[2:0]; nb = n;
        exp_rd = 0; L = m_lay; sel = r && c;
        if (op >= 1 && op <= 4) begin
            if (op == 1 && sel) exp_rd = m_code[L];
            if (sel && op == 2) begin m_code[L] = w; m_etch[L] = 0; end
            if (sel && op == 3) begin
                a = (L < NL - 1) && isx(m_code[(L < NL - 1) ? L + 1 : L]);
                b = (L > 0) && isx(m_code[(L > 0) ? L - 1 : L]);
                dir = n[3] ? 2 : n[2] ? 3 : n[1] ? 4 : n[0] ? 5 : a ? 6 : b ? 7 : -1;
                if (dir >= 0) begin
                    if (m_code[L] == 0) m_code[L] = dir;
                    else if (m_code[L] == 1 && e) begin m_code[L] = dir; m_etch[L] = 1; end
                end
            end
            if (sel && op == 4 && isx(m_code[L])) begin
                m_code[L] = m_etch[L] ? 1 : 0;
                m_etch[L] = 0;
            end
            m_lay = (L + 1) % NL;
        end
        sb_q.push_back('{cyc + 1, exp_rd, m_lay, req});
    endtask

    // Monitor: compare read data and layer index when each result is due.
    always @(negedge clk) begin
        while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
            exp_t it;
            it = sb_q.pop_front();
            check({it.req, " rd"}, int'(rd_o), it.rd);
            check({it.req, " R2 layer"}, int'(layer_o), it.lay);
        end
    end

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            cmd = '0; nb = '0; et = 1'b0;
        end
    endtask

    task automatic probe(bit r, bit c, int exp_xp, int exp_st, string req);
        @(posedge clk); #1;
        cmd = '0; rs = r; cs = c; nb = '0;
        #2;
        check({req, " R10 xp"}, int'(xp_o), exp_xp);
        check({req, " R11 status"}, int'(status_o), exp_st);
        check({req, " R2 layer"}, int'(layer_o), m_lay);
    endtask

    task automatic rpass(string req);
        for (int i = 0; i < NL; i++) issue(1, 1, 1, 0, 0, 4'b0, req);
    endtask

    task automatic wpass(int c0, int c1, int c2, int c3);
        issue(2, 1, 1, 0, c0, 4'b0, "R3");
        issue(2, 1, 1, 0, c1, 4'b0, "R3");
        issue(2, 1, 1, 0, c2, 4'b0, "R3");
        issue(2, 1, 1, 0, c3, 4'b0, "R3");
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NL; i++) begin m_code[i] = 0; m_etch[i] = 0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #2;
        // R1 reset state
        check("R1 layer", int'(layer_o), 0);
        check("R1 rd", int'(rd_o), 0);
        check("R1 xp", int'(xp_o), 0);
        check("R1 status", int'(status_o), 1);
        rpass("R1");
        // R2 NOP and unused codes hold the layer
        issue(0, 1, 1, 0, 0, 4'b0, "R2");
        issue(6, 1, 1, 0, 0, 4'b0, "R2");
        idle(2);
        probe(1, 1, 0, 1, "R2 hold");
        // R3 writes gated by both selects
        issue(2, 1, 1, 0, 1, 4'b0, "R3");
        issue(2, 0, 1, 0, 4, 4'b0, "R3");
        issue(2, 1, 0, 0, 7, 4'b0, "R3");
        issue(2, 1, 1, 0, 1, 4'b0, "R3");
        rpass("R3 R4");
        // R5 planar priority, R6 no etch
        issue(3, 1, 1, 0, 0, 4'b1111, "R6");
        issue(3, 1, 1, 0, 0, 4'b1100, "R5");
        issue(3, 1, 1, 0, 0, 4'b0110, "R5");
        issue(3, 1, 1, 0, 0, 4'b0001, "R6");
        issue(1, 1, 1, 0, 0, 4'b0, "R6");
        idle(1);
        probe(1, 1, 1, 0, "R10 R11");
        probe(1, 0, 1, 1, "R11");
        for (int i = 1; i < NL; i++) issue(1, 1, 1, 0, 0, 4'b0, "R5");
        // R6 etching, R7 already expanded holds
        issue(3, 1, 1, 1, 0, 4'b0010, "R6");
        issue(3, 1, 1, 1, 0, 4'b1000, "R7");
        issue(3, 1, 1, 1, 0, 4'b0000, "R7");
        issue(3, 1, 1, 1, 0, 4'b0001, "R6");
        rpass("R6 R7");
        // R9 clear, one layer unselected
        issue(4, 1, 1, 0, 0, 4'b0, "R9");
        issue(4, 1, 1, 0, 0, 4'b0, "R9");
        issue(4, 0, 1, 0, 0, 4'b0, "R9");
        issue(4, 1, 1, 0, 0, 4'b0, "R9");
        rpass("R9");
        // R8 up over down priority
        wpass(2, 0, 0, 4);
        for (int i = 0; i < NL; i++) issue(3, 1, 1, 0, 0, 4'b0, "R8");
        rpass("R8 both");
        // R8 bottom ignores the top layer
        wpass(0, 0, 0, 2);
        for (int i = 0; i < NL; i++) issue(3, 1, 1, 0, 0, 4'b0, "R8");
        rpass("R8 bottom R7");
        // R8 top ignores the bottom layer
        wpass(5, 0, 1, 0);
        for (int i = 0; i < NL; i++) issue(3, 1, 1, 0, 0, 4'b0, "R8");
        rpass("R8 top");
        // R5 east over west, west over down
        wpass(0, 0, 0, 0);
        issue(3, 1, 1, 0, 0, 4'b0011, "R5");
        issue(3, 1, 1, 0, 0, 4'b0001, "R5");
        issue(3, 1, 1, 0, 0, 4'b0001, "R5");
        issue(3, 1, 1, 0, 0, 4'b0000, "R5");
        rpass("R5 EW");
        idle(3);
        check("R4 scoreboard drained", sb_q.size(), 0);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule